// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one whole NAND flash transaction on an 8-bit asynchronous flash bus from a single start pulse. Before the launch, the host places up to two column address bytes, up to three row address bytes, two command opcodes, a byte count and a 16-bit phase-enable word on the block's inputs. On `start` the block latches all of them and walks a fixed list of bus phases. It skips every phase whose enable bit is clear. Page reads, page programs, erases, status polls and bare commands therefore all come from the same sequence.

Payload bytes move between the bus and an internal word-addressed buffer. The buffer holds one page plus its spare area, and the host fills it or reads it back through a plain word port while the block is idle. In each 32-bit word the first bus byte sits in the most significant lane. The ready/busy phase waits for the device to drop R/B# and raise it again, and a timeout bounds that wait. When the last enabled phase ends, chip enable is released and `done` rises.

The buffer port is a plain register-file port with no back-pressure. A host write is taken in the cycle it is presented if the block is idle, and is dropped while the block is busy. Bus bytes are paced only by the programmed strobe width and by R/B#. There is no valid/ready stall anywhere.

Top module: `nand_seq`

## Requirements
- R1: Enabled phases run in this order: first command (`op_code[14]`), column byte 0 (`[13]`), column byte 1 (`[12]`), row byte 0 (`[11]`), row byte 1 (`[10]`), row byte 2 (`[9]`), write data (`[8]`), second command (`[7]`), ready/busy wait (`[6]`), read data (`[5]`). A phase whose bit is clear is skipped.
- R2: Address byte n of `col_addr` / `row_addr` is taken from bits 8n+7..8n. Each address byte is enabled on its own bit, so at most five address cycles are issued.
- R3: Command cycles drive CLE=1 and ALE=0. Address cycles drive ALE=1 and CLE=0. Data cycles drive both low. `nand_dq_oe` is high whenever WE# is low and low whenever RE# is low.
- R4: Every bus byte has one WE# or RE# low pulse lasting exactly T clocks, followed by at least T high clocks before the next pulse. T = `strobe_clks`, but values below 2 are used as 2.
- R5: The write-data phase sends `xfer_len` bytes starting at buffer byte 0. Bus byte p comes from word p/4, lane (p XOR 3), where lane 3 is bits 31:24.
- R6: The read-data phase stores `xfer_len` bytes from byte 0, placing bus byte p in word p/4, lane (p XOR 3). Other lanes of the buffer are left unchanged.
- R7: A data phase with `xfer_len` = 0 produces no strobes, even when its enable bit is set.
- R8: The wait phase ends once R/B# has been seen low and then high. If that has not happened after TMO_CLKS clocks, the phase ends anyway, `rb_timeout` is set, and the sequence continues. `rb_timeout` is cleared by the next start.
- R9: `busy` is high from the accepted start until the end of the sequence. `done` rises as `busy` falls and is held until the next start. A start pulse while busy is ignored.
- R10: `nand_ce_n` is low during every strobe of an operation and is high whenever the block is idle.
- R11: `op_code` bits 15 and 4..0 have no effect on the bus traffic.
- R12: The host port writes a whole word when idle, reads a word combinationally, and its writes are dropped while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse |
| op_code | input | 16 | Phase-enable word |
| col_addr | input | 16 | Column address bytes |
| row_addr | input | 24 | Row address bytes |
| cmd_first | input | 8 | First command opcode |
| cmd_second | input | 8 | Second command opcode |
| xfer_len | input | LEN_W (12) | Data phase byte count |
| strobe_clks | input | TW (4) | Strobe low/high width in clocks |
| host_we | input | 1 | Host buffer word write |
| host_addr | input | AW (10) | Host buffer word address |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| rb_timeout | output | 1 | Ready/busy wait timed out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to flash |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from flash |
| nand_rb_n | input | 1 | Ready/busy from flash |

## Verification
The in-line assertions watch the bus on every cycle. They check that CLE and ALE are exclusive and that only one strobe is low at a time. They check that the output enable follows the strobe direction, that no strobe is shorter than two clocks, and that the data counter stays below the length. They also check that chip enable covers the whole busy window, that latched parameters stay frozen while busy, and that a timeout is raised only from the wait phase. What only the scenarios can show is the exact byte order and opcode placement, the big-endian buffer lanes, how skipped phases and zero lengths combine, the timeout against a silent R/B#, and that starts and host writes during an operation leave no trace.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [3:0] {
    ST_CMD1, ST_COL0, ST_COL1, ST_ROW0, ST_ROW1, ST_ROW2,
    ST_WDAT, ST_CMD2, ST_WAIT, ST_RDAT, ST_END
  } step_e;

  typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} bkind_e;

  localparam int NUM_STEPS = 10;
endpackage

// File: rtl/nseq_buf.sv
module nseq_buf #(
  parameter int WORDS = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    wbe,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [31:0]   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_b
);
  logic [31:0] mem [WORDS];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wbe[l] && (int'(waddr) < WORDS))
        mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  assign rdata_a = (int'(raddr_a) < WORDS) ? mem[raddr_a] : 32'h0;
  assign rdata_b = (int'(raddr_b) < WORDS) ? mem[raddr_b] : 32'h0;
endmodule

// File: rtl/nseq_bus.sv
module nseq_bus import nseq_pkg::*; #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  bkind_e        kind,
  input  logic [7:0]    tx_byte,
  input  logic [TW-1:0] tcfg,
  output logic          fin,
  output logic [7:0]    rx_byte,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  input  logic [7:0]    dq_in
);
  typedef enum logic [1:0] {B_IDLE, B_LO, B_HI} bst_e;
  bst_e          st;
  logic [TW-1:0] tlim, cnt;
  logic          is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE; tlim <= TW'(2); cnt <= '0; is_rd <= 1'b0;
      fin <= 1'b0; rx_byte <= 8'h00; cle <= 1'b0; ale <= 1'b0;
      we_n <= 1'b1; re_n <= 1'b1; dq_out <= 8'h00; dq_oe <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        B_IDLE: if (go) begin
          st     <= B_LO;
          cnt    <= TW'(1);
          tlim   <= (tcfg < TW'(2)) ? TW'(2) : tcfg;
          is_rd  <= (kind == BK_RD);
          cle    <= (kind == BK_CMD);
          ale    <= (kind == BK_ADDR);
          dq_oe  <= (kind != BK_RD);
          dq_out <= (kind == BK_RD) ? 8'h00 : tx_byte;
          if (kind == BK_RD) re_n <= 1'b0;
          else               we_n <= 1'b0;
        end
        B_LO: if (cnt == tlim) begin
          st   <= B_HI;
          cnt  <= TW'(1);
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (is_rd) rx_byte <= dq_in;
        end else cnt <= cnt + TW'(1);
        B_HI: if (cnt == tlim) begin
          st    <= B_IDLE;
          fin   <= 1'b1;
          cle   <= 1'b0;
          ale   <= 1'b0;
          dq_oe <= 1'b0;
        end else cnt <= cnt + TW'(1);
        default: st <= B_IDLE;
      endcase
    end
  end

  a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r3_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  a_r3_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
  a_r4_we_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |=> !we_n);
  a_r4_re_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |=> !re_n);
endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl import nseq_pkg::*; #(
  parameter int LEN_W    = 12,
  parameter int AW       = 10,
  parameter int TMO_CLKS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      code,
  input  logic [15:0]      col,
  input  logic [23:0]      row,
  input  logic [7:0]       cmd_a,
  input  logic [7:0]       cmd_b,
  input  logic [LEN_W-1:0] len,
  input  logic             rb_s,
  input  logic             fin,
  input  logic [7:0]       rx_byte,
  input  logic [31:0]      buf_rdata,
  output logic             go,
  output bkind_e           kind,
  output logic [7:0]       tx_byte,
  output logic             buf_we,
  output logic [3:0]       buf_wbe,
  output logic [AW-1:0]    buf_addr,
  output logic [31:0]      buf_wdata,
  output logic             busy,
  output logic             done,
  output logic             rb_timeout,
  output logic             ce_n
);
  localparam int TMO_W = $clog2(TMO_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_XFER, S_WLO, S_WHI} cst_e;
  cst_e             state;
  step_e            step, nxt;
  logic             found;
  logic [15:0]      code_q, col_q;
  logic [23:0]      row_q;
  logic [7:0]       ca_q, cb_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [TMO_W-1:0] tmo;
  logic [1:0]       lane;
  logic [7:0]       wbyte;
  logic             in_data;

  function automatic logic step_on(input step_e s);
    case (s)
      ST_CMD1: step_on = code_q[14];
      ST_COL0: step_on = code_q[13];
      ST_COL1: step_on = code_q[12];
      ST_ROW0: step_on = code_q[11];
      ST_ROW1: step_on = code_q[10];
      ST_ROW2: step_on = code_q[9];
      ST_WDAT: step_on = code_q[8] && (len_q != '0);
      ST_CMD2: step_on = code_q[7];
      ST_WAIT: step_on = code_q[6];
      ST_RDAT: step_on = code_q[5] && (len_q != '0);
      default: step_on = 1'b0;
    endcase
  endfunction

  always_comb begin
    found = 1'b0;
    nxt   = ST_END;
    for (int i = NUM_STEPS - 1; i >= 0; i--) begin
      if (i >= int'(step) && step_on(step_e'(4'(i)))) begin
        found = 1'b1;
        nxt   = step_e'(4'(i));
      end
    end
  end

  assign lane      = ~cnt[1:0];
  assign buf_addr  = AW'(cnt >> 2);
  assign wbyte     = buf_rdata[8*lane +: 8];
  assign in_data   = (step == ST_WDAT) || (step == ST_RDAT);
  assign buf_we    = (state == S_XFER) && fin && (step == ST_RDAT);
  assign buf_wbe   = 4'b0001 << lane;
  assign buf_wdata = {4{rx_byte}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; step <= ST_CMD1; code_q <= '0; col_q <= '0; row_q <= '0;
      ca_q <= '0; cb_q <= '0; len_q <= '0; cnt <= '0; tmo <= '0;
      go <= 1'b0; kind <= BK_CMD; tx_byte <= 8'h00;
      busy <= 1'b0; done <= 1'b0; rb_timeout <= 1'b0; ce_n <= 1'b1;
    end else begin
      go <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          code_q <= code; col_q <= col; row_q <= row;
          ca_q <= cmd_a; cb_q <= cmd_b; len_q <= len;
          busy <= 1'b1; done <= 1'b0; rb_timeout <= 1'b0; ce_n <= 1'b0;
          step <= ST_CMD1; cnt <= '0; state <= S_NEXT;
        end
        S_NEXT: if (!found) begin
          state <= S_IDLE; busy <= 1'b0; done <= 1'b1; ce_n <= 1'b1;
        end else begin
          step <= nxt;
          if (nxt == ST_WAIT) begin
            state <= S_WLO;
            tmo   <= '0;
          end else begin
            go    <= 1'b1;
            state <= S_XFER;
            case (nxt)
              ST_CMD1: begin kind <= BK_CMD;  tx_byte <= ca_q;         end
              ST_COL0: begin kind <= BK_ADDR; tx_byte <= col_q[7:0];   end
              ST_COL1: begin kind <= BK_ADDR; tx_byte <= col_q[15:8];  end
              ST_ROW0: begin kind <= BK_ADDR; tx_byte <= row_q[7:0];   end
              ST_ROW1: begin kind <= BK_ADDR; tx_byte <= row_q[15:8];  end
              ST_ROW2: begin kind <= BK_ADDR; tx_byte <= row_q[23:16]; end
              ST_WDAT: begin kind <= BK_WR;   tx_byte <= wbyte;        end
              ST_CMD2: begin kind <= BK_CMD;  tx_byte <= cb_q;         end
              default: begin kind <= BK_RD;   tx_byte <= 8'h00;        end
            endcase
          end
        end
        S_XFER: if (fin) begin
          if (in_data && ((cnt + LEN_W'(1)) < len_q)) cnt <= cnt + LEN_W'(1);
          else begin
            cnt  <= '0;
            step <= step_e'(step + 4'd1);
          end
          state <= S_NEXT;
        end
        S_WLO, S_WHI: begin
          tmo <= tmo + TMO_W'(1);
          if ((state == S_WHI) && rb_s) begin
            step  <= step_e'(step + 4'd1);
            state <= S_NEXT;
          end else if (tmo == TMO_W'(TMO_CLKS - 1)) begin
            rb_timeout <= 1'b1;
            step       <= step_e'(step + 4'd1);
            state      <= S_NEXT;
          end else if ((state == S_WLO) && !rb_s) state <= S_WHI;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER && in_data) |-> (cnt < len_q));
  a_r8_timeout_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_timeout) |-> $past(state == S_WLO || state == S_WHI));
  a_r9_done_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(code_q) && $stable(len_q)));
  a_r10_ce_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ce_n);
endmodule

// File: rtl/nand_seq.sv
module nand_seq import nseq_pkg::*; #(
  parameter  int PAGE_BYTES  = 2048,
  parameter  int SPARE_BYTES = 64,
  parameter  int TMO_CLKS    = 65536,
  parameter  int TW          = 4,
  localparam int BUF_BYTES   = PAGE_BYTES + SPARE_BYTES,
  localparam int BUF_WORDS   = (BUF_BYTES + 3) / 4,
  localparam int AW          = $clog2(BUF_WORDS),
  localparam int LEN_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      op_code,
  input  logic [15:0]      col_addr,
  input  logic [23:0]      row_addr,
  input  logic [7:0]       cmd_first,
  input  logic [7:0]       cmd_second,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [TW-1:0]    strobe_clks,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             busy,
  output logic             done,
  output logic             rb_timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb_n
);
  logic [1:0]    rb_meta;
  logic          go, fin, c_we;
  bkind_e        kind;
  logic [7:0]    tx_byte, rx_byte;
  logic [3:0]    c_wbe;
  logic [AW-1:0] c_addr;
  logic [31:0]   c_wdata, c_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_meta <= 2'b11;
    else        rb_meta <= {rb_meta[0], nand_rb_n};
  end

  nseq_ctrl #(.LEN_W(LEN_W), .AW(AW), .TMO_CLKS(TMO_CLKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .code(op_code), .col(col_addr),
    .row(row_addr), .cmd_a(cmd_first), .cmd_b(cmd_second), .len(xfer_len),
    .rb_s(rb_meta[1]), .fin(fin), .rx_byte(rx_byte), .buf_rdata(c_rdata),
    .go(go), .kind(kind), .tx_byte(tx_byte), .buf_we(c_we), .buf_wbe(c_wbe),
    .buf_addr(c_addr), .buf_wdata(c_wdata), .busy(busy), .done(done),
    .rb_timeout(rb_timeout), .ce_n(nand_ce_n)
  );

  nseq_bus #(.TW(TW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .tx_byte(tx_byte),
    .tcfg(strobe_clks), .fin(fin), .rx_byte(rx_byte), .cle(nand_cle),
    .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
    .dq_oe(nand_dq_oe), .dq_in(nand_dq_in)
  );

  nseq_buf #(.WORDS(BUF_WORDS), .AW(AW)) u_buf (
    .clk(clk),
    .we(busy ? c_we : host_we),
    .wbe(busy ? c_wbe : 4'hF),
    .waddr(busy ? c_addr : host_addr),
    .wdata(busy ? c_wdata : host_wdata),
    .raddr_a(c_addr), .rdata_a(c_rdata),
    .raddr_b(host_addr), .rdata_b(host_rdata)
  );
endmodule

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 528;
  localparam int MAXEV = 4400;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] op_code = '0, col_addr = '0;
  logic [23:0] row_addr = '0;
  logic [7:0] cmd_first = '0, cmd_second = '0;
  logic [11:0] xfer_len = '0;
  logic [3:0] strobe_clks = 4'd2;
  logic host_we = 1'b0;
  logic [9:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic busy, done, rb_timeout, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out;
  logic [7:0] nand_dq_in = 8'h00;
  logic nand_rb_n = 1'b1;

  nand_seq #(.TMO_CLKS(300)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] bmw [WORDS];
  logic [1:0] exp_k [MAXEV]; logic [7:0] exp_b [MAXEV];
  logic [1:0] got_k [MAXEV]; logic [7:0] got_b [MAXEV];
  int n_exp = 0, n_got = 0, rd_idx = 0, rb_cnt = 0;
  int w_bad = 0, ce_bad = 0, lo_run = 0, hi_run = 0, t_exp = 2;
  bit logging = 0, arm_rb = 0, seen = 0;
  logic [7:0] cur_cb = 8'h00, rd_seed = 8'h11;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rdpat(input int p);
    return 8'((p * 37 + int'(rd_seed)) & 255);
  endfunction

  function automatic logic [7:0] bm_byte(input int p);
    return bmw[p/4][8*(3 - (p % 4)) +: 8];
  endfunction

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    exp_k[n_exp] = k; exp_b[n_exp] = b; n_exp++;
  endtask

  // bus monitors and flash model
  always @(posedge nand_we_n) if (logging && n_got < MAXEV) begin
    got_k[n_got] = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
    got_b[n_got] = nand_dq_out;
    n_got++;
    if (nand_ce_n) ce_bad++;
    if (arm_rb && nand_cle && nand_dq_out == cur_cb) rb_cnt = 20;
  end
  always @(negedge nand_re_n) if (logging && n_got < MAXEV) begin
    got_k[n_got] = 2'd3; got_b[n_got] = nand_dq_in; n_got++;
    if (nand_ce_n) ce_bad++;
  end
  always @(posedge nand_re_n) if (logging) begin
    rd_idx++; nand_dq_in = rdpat(rd_idx);
  end
  always @(negedge clk) begin
    if (rb_cnt > 0) begin nand_rb_n = 1'b0; rb_cnt--; end
    else nand_rb_n = 1'b1;
    if (logging) begin
      if (!nand_we_n || !nand_re_n) begin
        if (seen && hi_run > 0 && hi_run < t_exp) w_bad++;
        hi_run = 0; lo_run++; seen = 1;
      end else begin
        if (lo_run > 0) begin if (lo_run != t_exp) w_bad++; lo_run = 0; end
        if (seen) hi_run++;
      end
    end
  end

  task automatic host_rd(input int w, output logic [31:0] d);
    @(negedge clk); host_addr = 10'(w); #1 d = host_rdata;
  endtask

  task automatic run_op(input logic [15:0] c, input logic [15:0] col, input logic [23:0] row,
                        input logic [7:0] ca, input logic [7:0] cb, input int len, input int tc,
                        input bit arm, input int mode, input string tag);
    int cyc, mis, nbad, lastw;
    bit exp_err;
    logic [31:0] d;
    n_exp = 0;
    if (c[14]) push(2'd0, ca);
    if (c[13]) push(2'd1, col[7:0]);
    if (c[12]) push(2'd1, col[15:8]);
    if (c[11]) push(2'd1, row[7:0]);
    if (c[10]) push(2'd1, row[15:8]);
    if (c[9])  push(2'd1, row[23:16]);
    if (c[8]) for (int p = 0; p < len; p++) push(2'd2, bm_byte(p));
    if (c[7]) push(2'd0, cb);
    if (c[5]) for (int p = 0; p < len; p++) push(2'd3, rdpat(p));
    exp_err = c[6] && !(c[7] && arm);
    @(negedge clk);
    op_code = c; col_addr = col; row_addr = row; cmd_first = ca; cmd_second = cb;
    xfer_len = 12'(len); strobe_clks = 4'(tc); arm_rb = arm; cur_cb = cb;
    n_got = 0; rd_idx = 0; nand_dq_in = rdpat(0); w_bad = 0; ce_bad = 0;
    lo_run = 0; hi_run = 0; seen = 0; t_exp = (tc < 2) ? 2 : tc; logging = 1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk); cyc++;
      if (cyc == 6 && mode == 1) begin start = 1'b1; op_code = 16'h4000; cmd_first = 8'hEE; end
      if (cyc == 6 && mode == 2) begin host_we = 1'b1; host_addr = 10'd0; host_wdata = 32'hDEADBEEF; end
      if (cyc == 7) begin start = 1'b0; host_we = 1'b0; end
    end
    repeat (mode == 1 ? 20 : 5) @(negedge clk);
    logging = 0;
    mis = -1;
    for (int i = n_exp - 1; i >= 0; i--)
      if (i < n_got && (got_k[i] != exp_k[i] || got_b[i] != exp_b[i])) mis = i;
    chk(n_got == n_exp, "R1", {tag, " bus byte count"}, n_got, n_exp);
    chk(mis < 0, "R1/R2/R3/R5", {tag, " first mismatching bus byte index"}, mis, -1);
    chk(w_bad == 0, "R4", {tag, " strobe width errors"}, w_bad, 0);
    chk(ce_bad == 0 && nand_ce_n == 1'b1, "R10", {tag, " chip enable"}, ce_bad, 0);
    chk(done == 1'b1 && busy == 1'b0, "R9", {tag, " done/busy at end"}, {30'd0, done, busy}, 2);
    chk(rb_timeout == exp_err, "R8", {tag, " timeout flag"}, int'(rb_timeout), int'(exp_err));
    if (c[5] && len > 0) begin
      for (int p = 0; p < len; p++) bmw[p/4][8*(3 - (p % 4)) +: 8] = rdpat(p);
      lastw = (len + 3) / 4;
      if (lastw > WORDS - 1) lastw = WORDS - 1;
      nbad = 0;
      for (int w = 0; w <= lastw; w++) begin host_rd(w, d); if (d != bmw[w]) nbad++; end
      chk(nbad == 0, "R6", {tag, " buffer words wrong after read"}, nbad, 0);
    end
    if (mode == 2) begin
      host_rd(0, d);
      chk(d == bmw[0], "R12", {tag, " host write while busy"}, int'(d), int'(bmw[0]));
    end
    repeat (25) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] ca;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !rb_timeout,
        "R9/R10", "reset state", {25'd0, busy, done, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 28);
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk); host_we = 1'b1; host_addr = 10'(w); bmw[w] = $urandom; host_wdata = bmw[w];
    end
    @(negedge clk); host_we = 1'b0;
    host_rd(5, d);
    chk(d == bmw[5], "R12", "host word readback", int'(d), int'(bmw[5]));

    run_op(16'h7CE0, 16'h0123, 24'h045678, 8'h00, 8'h30, 16, 2, 1, 0, "page read");
    run_op(16'h7FC0, 16'h00A5, 24'h3C5A69, 8'h80, 8'h10, 13, 3, 1, 0, "page program");
    run_op(16'h7FE0, 16'h1111, 24'h222222, 8'h85, 8'h15, 0, 2, 1, 0, "R7 zero length");
    run_op(16'h40C0, 16'h0, 24'h0, 8'h60, 8'hD0, 0, 2, 0, 0, "R8 silent ready/busy");
    run_op(16'h4000, 16'h0, 24'h0, 8'hFF, 8'h5A, 0, 2, 1, 0, "R8 flag cleared");
    run_op(16'hC01F, 16'h0, 24'h0, 8'h70, 8'h2A, 8, 2, 1, 0, "R11 ignored bits");
    run_op(16'h4A80, 16'h0, 24'h00BEEF, 8'h12, 8'h34, 0, 4, 1, 1, "R9 start while busy");
    run_op(16'h7F80, 16'h0002, 24'h000010, 8'h80, 8'h10, 20, 3, 1, 2, "R12 host write while busy");
    run_op(16'h6920, 16'h0044, 24'h000077, 8'h05, 8'hE0, 7, 0, 1, 0, "R4 width floor");
    rd_seed = 8'h9C;
    run_op(16'h7CE0, 16'h0000, 24'h001234, 8'h00, 8'h30, 2112, 2, 1, 0, "R5/R6 full page+spare");
    for (int i = 0; i < 30; i++) begin
      ca = 8'($urandom);
      rd_seed = 8'($urandom);
      run_op(16'($urandom), 16'($urandom), 24'($urandom), ca, ca ^ 8'h5A,
             int'($urandom % 48), int'($urandom % 6), 1, 0, "random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule